// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the scan timing for a parallel LCD panel. Software sets the geometry through three 32-bit timing words: horizontal, vertical, and a control word. The control word holds the clocks-per-line count, the sync polarity bits and the dual-panel bit. The block runs a pixel counter and a line counter that advance on a pixel clock enable. From them it drives horizontal sync, vertical sync and a data-enable strobe, and it reports the coordinate of the active pixel. Each line is laid out as sync, back porch, active, front porch. Each frame has the same layout counted in lines.

Writes go into shadow copies. The working copies that drive the counters reload from the shadows at the start of each frame, and they follow the shadows continuously while the block is disabled. A geometry change made in the middle of a frame therefore never tears the raster. A configuration error output checks the shadow contents against the legal ranges at all times. It also checks that the clocks-per-line field agrees with the programmed active width, so software sees a bad write one cycle after making it.

Top module: `lcd_timing_gen`

## Requirements
- R1: Horizontal word fields: active width = 16*(bits[7:2]+1) pixels, hsync = bits[15:8]+1, front porch = bits[23:16]+1, back porch = bits[31:24]+1. A line is hsync, back porch, active, front porch. Sync is asserted during the first hsync pixels of the line.
- R2: Vertical word fields: active = bits[9:0]+1 lines, vsync = bits[15:10]+1 lines, front porch = bits[23:16] lines, back porch = bits[31:24] lines (these two have no offset). A frame is vsync, back porch, active, front porch lines.
- R3: Control bit 18 set (dual panel) makes the frame's active line count 2*(bits[9:0]+1).
- R4: Control bit 16 inverts hsync_o and control bit 17 inverts vsync_o. When the bit is clear the sync is active high.
- R5: de_o is high only when both counters are in their active regions. pix_x_o and line_y_o give the offset from the start of the active region while de_o is high, and 0 otherwise.
- R6: cfg_err_o is high one cycle after the shadow holds an hsync, horizontal front porch or horizontal back porch field below 5 (less than 6 clocks), or a vsync field above 31 (more than 32 lines).
- R7: cfg_err_o is also high when control bits[9:0] (clocks per line minus 1) differ from the active width minus 1.
- R8: Write select 0/1/2 (horizontal/vertical/control) loads a shadow. The working copies take the shadow only on the pixel-enabled clock that wraps the frame back to pixel 0, line 0, or while the block is disabled. A write in that wrap cycle misses that frame.
- R9: While disabled the counters clear, de_o and the coordinates are 0 and the syncs sit at their inactive level. Enabling starts at pixel 0, line 0 one clock after enable_i rises.
- R10: Without pix_ce_i the counters and all timing outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 horizontal, 1 vertical, 2 control |
| wr_data_i | input | 32 | Write data |
| pix_ce_i | input | 1 | Pixel clock enable |
| enable_i | input | 1 | Timing generator enable |
| hsync_o | output | 1 | Horizontal sync, polarity per control bit 16 |
| vsync_o | output | 1 | Vertical sync, polarity per control bit 17 |
| de_o | output | 1 | Data enable |
| pix_x_o | output | HCW | Active pixel column |
| line_y_o | output | VCW | Active line row |
| cfg_err_o | output | 1 | Shadow configuration is illegal |

## Verification
Two functions can land in the same clock: a register write and the frame-wrap reload of the working copies. The bench provokes this by running with the pixel enable always high. It watches its reference model until the model reaches the last pixel of the last line, and it issues the write on that very cycle. The model applies the old shadow to the new frame and the written value one frame later, and every clock is compared against it. The check therefore fails if the design lets the fresh write slip into the frame that is just starting.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  typedef enum logic [1:0] {
    SEL_HORZ = 2'd0,
    SEL_VERT = 2'd1,
    SEL_CTRL = 2'd2
  } reg_sel_e;

  localparam int NUM_REGS      = 3;
  localparam int PORCH_MIN_FLD = 5;   // stored minus one: 6 clocks
  localparam int VSW_MAX_FLD   = 31;  // stored minus one: 32 lines

  function automatic logic [31:0] rst_word(input int idx);
    case (idx)
      0:       rst_word = 32'h0505_0500;
      1:       rst_word = 32'h0101_0001;
      default: rst_word = 32'h0000_000F;
    endcase
  endfunction
endpackage

// File: rtl/lcd_tg_regs.sv
module lcd_tg_regs
  import lcd_tg_pkg::*;
#(
  parameter int HCW = 12,
  parameter int VCW = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [1:0]     wr_sel_i,
  input  logic [31:0]    wr_data_i,
  input  logic           load_i,
  output logic [HCW-1:0] h_sync_len_o,
  output logic [HCW-1:0] h_bp_len_o,
  output logic [HCW-1:0] h_act_len_o,
  output logic [HCW-1:0] h_fp_len_o,
  output logic [VCW-1:0] v_sync_len_o,
  output logic [VCW-1:0] v_bp_len_o,
  output logic [VCW-1:0] v_act_len_o,
  output logic [VCW-1:0] v_fp_len_o,
  output logic           inv_h_o,
  output logic           inv_v_o,
  output logic           cfg_err_o
);
  localparam logic [HCW-1:0] ONE_H = HCW'(1);
  localparam logic [VCW-1:0] ONE_V = VCW'(1);

  logic [31:0] sh_q [NUM_REGS];
  logic [31:0] wk_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q[i] <= rst_word(i);
        wk_q[i] <= rst_word(i);
      end else begin
        if (load_i) wk_q[i] <= sh_q[i];
        if (wr_en_i && (wr_sel_i == 2'(i))) sh_q[i] <= wr_data_i;
      end
    end
  end

  logic [VCW-1:0] v_act_base;

  always_comb begin
    h_act_len_o  = (HCW'(wk_q[SEL_HORZ][7:2]) + ONE_H) << 4;
    h_sync_len_o = HCW'(wk_q[SEL_HORZ][15:8]) + ONE_H;
    h_fp_len_o   = HCW'(wk_q[SEL_HORZ][23:16]) + ONE_H;
    h_bp_len_o   = HCW'(wk_q[SEL_HORZ][31:24]) + ONE_H;
    v_act_base   = VCW'(wk_q[SEL_VERT][9:0]) + ONE_V;
    v_act_len_o  = wk_q[SEL_CTRL][18] ? (v_act_base << 1) : v_act_base;
    v_sync_len_o = VCW'(wk_q[SEL_VERT][15:10]) + ONE_V;
    v_fp_len_o   = VCW'(wk_q[SEL_VERT][23:16]);
    v_bp_len_o   = VCW'(wk_q[SEL_VERT][31:24]);
    inv_h_o      = wk_q[SEL_CTRL][16];
    inv_v_o      = wk_q[SEL_CTRL][17];
  end

  // legality is judged on the shadow so software sees it right after the write
  logic range_err, cpl_err;
  always_comb begin
    range_err = (int'(sh_q[SEL_HORZ][15:8])  < PORCH_MIN_FLD) ||
                (int'(sh_q[SEL_HORZ][23:16]) < PORCH_MIN_FLD) ||
                (int'(sh_q[SEL_HORZ][31:24]) < PORCH_MIN_FLD) ||
                (int'(sh_q[SEL_VERT][15:10]) > VSW_MAX_FLD);
    cpl_err   = sh_q[SEL_CTRL][9:0] != {sh_q[SEL_HORZ][7:2], 4'hF};
    cfg_err_o = range_err || cpl_err;
  end

  logic unused_bits;
  assign unused_bits = ^{wk_q[SEL_HORZ][1:0], wk_q[SEL_CTRL][15:0], wk_q[SEL_CTRL][31:19],
                         sh_q[SEL_HORZ][1:0], sh_q[SEL_VERT][9:0], sh_q[SEL_VERT][31:16],
                         sh_q[SEL_CTRL][31:10]};
endmodule

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         step_i,
  input  logic [W-1:0] sync_len_i,
  input  logic [W-1:0] bp_len_i,
  input  logic [W-1:0] act_len_i,
  input  logic [W-1:0] fp_len_i,
  output logic [W-1:0] coord_o,
  output logic         sync_o,
  output logic         act_o,
  output logic         last_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, act_start, act_end, total;

  always_comb begin
    act_start = sync_len_i + bp_len_i;
    act_end   = act_start + act_len_i;
    total     = act_end + fp_len_i;
    last_o    = cnt_q == (total - ONE);
    sync_o    = cnt_q < sync_len_i;
    act_o     = (cnt_q >= act_start) && (cnt_q < act_end);
    coord_o   = act_o ? (cnt_q - act_start) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (step_i)  cnt_q <= last_o ? '0 : cnt_q + ONE;
  end
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter int HCW = 12,
  parameter int VCW = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [1:0]     wr_sel_i,
  input  logic [31:0]    wr_data_i,
  input  logic           pix_ce_i,
  input  logic           enable_i,
  output logic           hsync_o,
  output logic           vsync_o,
  output logic           de_o,
  output logic [HCW-1:0] pix_x_o,
  output logic [VCW-1:0] line_y_o,
  output logic           cfg_err_o
);
  logic run_q;
  logic h_step, v_step, frame_wrap, load;
  logic [HCW-1:0] h_sync_len, h_bp_len, h_act_len, h_fp_len, h_coord;
  logic [VCW-1:0] v_sync_len, v_bp_len, v_act_len, v_fp_len, v_coord;
  logic inv_h_w, inv_v_w;
  logic h_sync, h_act, h_last, v_sync, v_act, v_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= enable_i;
  end

  assign h_step     = run_q && pix_ce_i;
  assign v_step     = h_step && h_last;
  assign frame_wrap = v_step && v_last;
  assign load       = !run_q || frame_wrap;

  lcd_tg_regs #(.HCW(HCW), .VCW(VCW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .load_i       (load),
    .h_sync_len_o (h_sync_len),
    .h_bp_len_o   (h_bp_len),
    .h_act_len_o  (h_act_len),
    .h_fp_len_o   (h_fp_len),
    .v_sync_len_o (v_sync_len),
    .v_bp_len_o   (v_bp_len),
    .v_act_len_o  (v_act_len),
    .v_fp_len_o   (v_fp_len),
    .inv_h_o      (inv_h_w),
    .inv_v_o      (inv_v_w),
    .cfg_err_o
  );

  lcd_tg_axis #(.W(HCW)) u_h (
    .clk_i, .rst_ni,
    .run_i      (run_q),
    .step_i     (h_step),
    .sync_len_i (h_sync_len),
    .bp_len_i   (h_bp_len),
    .act_len_i  (h_act_len),
    .fp_len_i   (h_fp_len),
    .coord_o    (h_coord),
    .sync_o     (h_sync),
    .act_o      (h_act),
    .last_o     (h_last)
  );

  lcd_tg_axis #(.W(VCW)) u_v (
    .clk_i, .rst_ni,
    .run_i      (run_q),
    .step_i     (v_step),
    .sync_len_i (v_sync_len),
    .bp_len_i   (v_bp_len),
    .act_len_i  (v_act_len),
    .fp_len_i   (v_fp_len),
    .coord_o    (v_coord),
    .sync_o     (v_sync),
    .act_o      (v_act),
    .last_o     (v_last)
  );

  always_comb begin
    hsync_o  = (run_q && h_sync) ^ inv_h_w;
    vsync_o  = (run_q && v_sync) ^ inv_v_w;
    de_o     = run_q && h_act && v_act;
    pix_x_o  = de_o ? h_coord : '0;
    line_y_o = de_o ? v_coord : '0;
  end
endmodule

// File: rtl/lcd_tg_chk.sv
module lcd_tg_chk #(
  parameter int HCW = 12,
  parameter int VCW = 12
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           run_q,
  input logic           enable_i,
  input logic           pix_ce_i,
  input logic           frame_wrap,
  input logic           inv_h_w,
  input logic           inv_v_w,
  input logic [HCW-1:0] h_act_len,
  input logic [VCW-1:0] v_act_len,
  input logic           hsync_o,
  input logic           vsync_o,
  input logic           de_o,
  input logic [HCW-1:0] pix_x_o,
  input logic [VCW-1:0] line_y_o
);
  localparam logic [HCW-1:0] ONE_H = HCW'(1);

  p_de_outside_hsync_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (hsync_o == inv_h_w) && (vsync_o == inv_v_w));

  p_x_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o && pix_ce_i && enable_i |=> !de_o || (pix_x_o == $past(pix_x_o) + ONE_H));

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !de_o && (pix_x_o == '0) && (line_y_o == '0) &&
               (hsync_o == inv_h_w) && (vsync_o == inv_v_w));

  p_ce_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && enable_i && !pix_ce_i |=> $stable(hsync_o) && $stable(vsync_o) &&
      $stable(de_o) && $stable(pix_x_o) && $stable(line_y_o));

  p_cfg_frame_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !frame_wrap |=> $stable(h_act_len) && $stable(v_act_len) &&
      $stable(inv_h_w) && $stable(inv_v_w));
endmodule

bind lcd_timing_gen lcd_tg_chk #(.HCW(HCW), .VCW(VCW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_q      (run_q),
  .enable_i   (enable_i),
  .pix_ce_i   (pix_ce_i),
  .frame_wrap (frame_wrap),
  .inv_h_w    (inv_h_w),
  .inv_v_w    (inv_v_w),
  .h_act_len  (h_act_len),
  .v_act_len  (v_act_len),
  .hsync_o    (hsync_o),
  .vsync_o    (vsync_o),
  .de_o       (de_o),
  .pix_x_o    (pix_x_o),
  .line_y_o   (line_y_o)
);

// File: tb/tb_lcd_timing_gen.sv
`timescale 1ns/1ps
module tb_lcd_timing_gen;
  localparam int HCW = 12;
  localparam int VCW = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = 2'd0;
  logic [31:0] wr_data_i = '0;
  logic pix_ce_i = 1'b1;
  logic enable_i = 1'b0;
  logic hsync_o, vsync_o, de_o, cfg_err_o;
  logic [HCW-1:0] pix_x_o;
  logic [VCW-1:0] line_y_o;

  always #5 clk = ~clk;

  lcd_timing_gen #(.HCW(HCW), .VCW(VCW)) dut (
    .clk_i(clk), .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i, .pix_ce_i, .enable_i,
    .hsync_o, .vsync_o, .de_o, .pix_x_o, .line_y_o, .cfg_err_o
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R1";
  int ce_mode = 0;
  int ce_cnt = 0;

  // ---------------- reference model ----------------
  logic [31:0] m_sh [3];
  logic [31:0] m_wk [3];
  int m_hc, m_vc;
  bit m_r;

  function automatic int f_hsw(logic [31:0] h); return int'(h[15:8]) + 1; endfunction
  function automatic int f_hfp(logic [31:0] h); return int'(h[23:16]) + 1; endfunction
  function automatic int f_hbp(logic [31:0] h); return int'(h[31:24]) + 1; endfunction
  function automatic int f_hact(logic [31:0] h); return (int'(h[7:2]) + 1) * 16; endfunction
  function automatic int f_vsw(logic [31:0] v); return int'(v[15:10]) + 1; endfunction
  function automatic int f_vfp(logic [31:0] v); return int'(v[23:16]); endfunction
  function automatic int f_vbp(logic [31:0] v); return int'(v[31:24]); endfunction
  function automatic int f_vact(logic [31:0] v, logic [31:0] c);
    return (int'(v[9:0]) + 1) * (c[18] ? 2 : 1);
  endfunction
  function automatic int tot_h(); return f_hsw(m_wk[0]) + f_hbp(m_wk[0]) + f_hact(m_wk[0]) + f_hfp(m_wk[0]); endfunction
  function automatic int tot_v(); return f_vsw(m_wk[1]) + f_vbp(m_wk[1]) + f_vact(m_wk[1], m_wk[2]) + f_vfp(m_wk[1]); endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_sh[0] = 32'h0505_0500; m_sh[1] = 32'h0101_0001; m_sh[2] = 32'h0000_000F;
      for (int i = 0; i < 3; i++) m_wk[i] = m_sh[i];
      m_hc = 0; m_vc = 0; m_r = 0;
    end else begin
      if (!m_r) begin
        m_hc = 0; m_vc = 0;
        for (int i = 0; i < 3; i++) m_wk[i] = m_sh[i];
      end else if (pix_ce_i) begin
        int th, tv;
        th = tot_h(); tv = tot_v();
        if (m_hc == th - 1) begin
          m_hc = 0;
          if (m_vc == tv - 1) begin
            m_vc = 0;
            for (int i = 0; i < 3; i++) m_wk[i] = m_sh[i];
          end else m_vc++;
        end else m_hc++;
      end
      if (wr_en_i && wr_sel_i < 2'd3) m_sh[wr_sel_i] = wr_data_i;
      m_r = enable_i;
    end
  end

  function automatic bit exp_err();
    return (m_sh[0][15:8] < 8'd5) || (m_sh[0][23:16] < 8'd5) || (m_sh[0][31:24] < 8'd5) ||
           (m_sh[1][15:10] > 6'd31) || (m_sh[2][9:0] != {m_sh[0][7:2], 4'hF});
  endfunction

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      int hs, hb, ha, vs, vb, va, ex, ey;
      bit e_hs, e_vs, e_de, bad;
      hs = f_hsw(m_wk[0]); hb = f_hbp(m_wk[0]); ha = f_hact(m_wk[0]);
      vs = f_vsw(m_wk[1]); vb = f_vbp(m_wk[1]); va = f_vact(m_wk[1], m_wk[2]);
      e_hs = (m_r && m_hc < hs) ^ m_wk[2][16];
      e_vs = (m_r && m_vc < vs) ^ m_wk[2][17];
      e_de = m_r && (m_hc >= hs + hb) && (m_hc < hs + hb + ha) &&
             (m_vc >= vs + vb) && (m_vc < vs + vb + va);
      ex = e_de ? m_hc - hs - hb : 0;
      ey = e_de ? m_vc - vs - vb : 0;
      bad = 0;
      n_chk++;
      if (hsync_o !== e_hs) begin bad = 1;
        $display("FAIL R1 hsync (%s) act=%0b exp=%0b", cur_req, hsync_o, e_hs); end
      if (vsync_o !== e_vs) begin bad = 1;
        $display("FAIL R2 vsync (%s) act=%0b exp=%0b", cur_req, vsync_o, e_vs); end
      if (de_o !== e_de) begin bad = 1;
        $display("FAIL R5 de (%s) act=%0b exp=%0b", cur_req, de_o, e_de); end
      if (int'(pix_x_o) != ex || int'(line_y_o) != ey) begin bad = 1;
        $display("FAIL R5 coord (%s) act=%0d,%0d exp=%0d,%0d", cur_req, pix_x_o, line_y_o, ex, ey); end
      if (cfg_err_o !== exp_err()) begin bad = 1;
        $display("FAIL R6 cfg_err (%s) act=%0b exp=%0b", cur_req, cfg_err_o, exp_err()); end
      if (bad) n_fail++;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      ce_cnt++;
      pix_ce_i = (ce_mode == 0) ? 1'b1 : (ce_cnt % 3 == 0);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    cur_req = "R9";
    chk("R9 reset hsync", 32'(hsync_o), 0);
    chk("R9 reset vsync", 32'(vsync_o), 0);
    chk("R9 reset de", 32'(de_o), 0);
    chk("R9 reset x", 32'(pix_x_o), 0);
    chk("R6 reset cfg_err", 32'(cfg_err_o), 0);

    // defaults, continuous pixel enable
    cur_req = "R1";
    enable_i = 1;
    run(520);

    // new horizontal geometry: cpl stale until control written
    cur_req = "R7";
    wr(2'd0, 32'h0508_0604);
    chk("R7 cpl mismatch", 32'(cfg_err_o), 1);
    wr(2'd2, 32'h0000_001F);
    chk("R7 cpl match", 32'(cfg_err_o), 0);
    cur_req = "R8";
    run(700);

    // vertical change with sparse pixel enable
    cur_req = "R2";
    ce_mode = 1;
    wr(2'd1, 32'h0300_0402);
    run(3000);

    // pixel enable gating
    cur_req = "R10";
    run(300);

    // inverted polarity and dual panel
    cur_req = "R3";
    wr(2'd2, 32'h0007_001F);
    run(4000);
    cur_req = "R4";
    ce_mode = 0;
    run(1300);

    // range violations
    cur_req = "R6";
    wr(2'd0, 32'h0508_0304);
    chk("R6 hsync too short", 32'(cfg_err_o), 1);
    wr(2'd0, 32'h0408_0604);
    chk("R6 back porch too short", 32'(cfg_err_o), 1);
    wr(2'd0, 32'h0508_0604);
    chk("R6 horizontal legal", 32'(cfg_err_o), 0);
    wr(2'd1, 32'h0300_A002);
    chk("R6 vsync too long", 32'(cfg_err_o), 1);
    wr(2'd1, 32'h0300_7C02);
    chk("R6 vsync 32 lines legal", 32'(cfg_err_o), 0);
    wr(2'd1, 32'h0300_0402);
    run(1300);

    // write landing in the frame-wrap cycle
    cur_req = "R8";
    @(negedge clk);
    while (!(m_r && m_hc == tot_h() - 1 && m_vc == tot_v() - 1)) @(negedge clk);
    wr_en_i = 1; wr_sel_i = 2'd0; wr_data_i = 32'h0505_0500;
    @(negedge clk);
    wr_en_i = 0;
    chk("R8 wrap write deferred", 32'(f_hact(m_wk[0])), 32);
    wr(2'd2, 32'h0000_000F);
    run(1400);

    // disable mid-frame and restart
    cur_req = "R9";
    run(37);
    enable_i = 0;
    run(6);
    chk("R9 idle de", 32'(de_o), 0);
    chk("R9 idle hsync", 32'(hsync_o), 0);
    enable_i = 1;
    run(600);

    finish_run();
  end
endmodule